// File: doc/BRIEF.md
# DMA Channel Launch and Interrupt Register File

This block holds the register state that governs a seven-channel DMA controller: one global control register, one interrupt register and one control word for each channel. A bus master reaches all of them through 32-bit register reads and writes on a 12-bit offset. A channel is launched only when two conditions meet. Its control word must be written with the launch bit set, and the channel's enable bit in the global control register must already be set. A launch is a single-cycle start pulse, presented together with the channel's stored control word, to the address and block-count engine that sits outside this block.

The interrupt register combines two kinds of bits. Its lower 24 bits take whatever is written. Its upper eight bits are channel completion flags. A flag is set by hardware when the channel reports completion while its interrupt enable is on. Software clears a flag by writing a one to that bit; a zero leaves it as it was. A completion report also drops the launch bit of that channel's control word, so software can see that the transfer has ended.

Top module: `dma_ctl_regs`

## Requirements
- R1: After reset every register reads zero and no start pulse is asserted.
- R2: A write to offset 0x088 + 0x10*n (n = 0..6) stores the full 32-bit word as channel n's control word. The word reads back at that offset and appears on that channel's slice of `ch_ctrl`.
- R3: When a channel control write has bit 24 set while bit (4n+3) of the global control register is set, `ch_start[n]` is high for exactly the one cycle after the write edge.
- R4: A channel control write with bit 24 clear, or with global bit (4n+3) clear, stores the word and raises no start pulse.
- R5: The global control register at offset 0x0F0 is a plain 32-bit read/write register.
- R6: A write to the interrupt register at offset 0x0F4 loads bits 23:0 directly from the written data.
- R7: On that write, each interrupt bit 24..31 is cleared where the written bit is 1 and is kept where it is 0.
- R8: A `ch_done[n]` pulse clears bit 24 of channel n's control word and leaves its other bits unchanged.
- R9: A `ch_done[n]` pulse sets interrupt flag bit (24+n) when interrupt enable bit (16+n) is 1 and leaves the flag untouched when it is 0.
- R10: When a flag clear and a done on the same channel share a cycle, the flag ends up set. When a control write and a done on the same channel share a cycle, the written word is kept.
- R11: Reads at unmapped offsets return zero, and writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W (12) | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ch_done | input | NUM_CH (7) | Per-channel completion pulse |
| ch_start | output | NUM_CH (7) | Per-channel one-cycle launch pulse |
| ch_ctrl | output | 32*NUM_CH | Stored control words, channel n at bits 32n+31:32n |

## Verification
The bench builds the block with its default parameters: seven channels and a 12-bit offset. At that size the last channel's control word at 0x0E8 sits next to the global register, so the decoder must separate neighbours on the full offset. Seven channels also leave interrupt bit 31 without a channel. That bit can still be cleared by a write and must never be set by a done pulse. The directed scenarios cover both launch gates, the clear-versus-set and write-versus-done collisions, and decoding at offsets between registers.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;

    localparam int REG_W        = 32;
    localparam int LAUNCH_BIT   = 24;
    localparam int IRQ_PLAIN_W  = 24;
    localparam int IRQ_EN_LSB   = 16;
    localparam int IRQ_FLAG_LSB = 24;
    localparam int IRQ_FLAG_W   = REG_W - IRQ_FLAG_LSB;
    localparam int GATE_STRIDE  = 4;
    localparam int GATE_OFFSET  = 3;

    localparam logic [11:0] GCTL_OFS    = 12'h0F0;
    localparam logic [11:0] IRQ_OFS     = 12'h0F4;
    localparam logic [11:0] CTRL_BASE   = 12'h088;
    localparam logic [11:0] CTRL_STRIDE = 12'h010;

    typedef struct packed {
        logic [REG_W-1:0] word;
        logic             start;
    } chan_state_t;

    function automatic logic [11:0] ctrl_ofs(input int n);
        return CTRL_BASE + 12'(n) * CTRL_STRIDE;
    endfunction

    function automatic int gate_bit(input int n);
        return GATE_STRIDE * n + GATE_OFFSET;
    endfunction

endpackage

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
    import dma_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [REG_W-1:0] wdata,
    input  logic             gate_en,
    input  logic             done,
    output logic [REG_W-1:0] word_o,
    output logic             start_o
);

    chan_state_t state_d, state_q;

    always_comb begin
        state_d       = state_q;
        state_d.start = 1'b0;
        if (done) begin
            state_d.word[LAUNCH_BIT] = 1'b0;
        end
        if (wr_hit) begin
            state_d.word  = wdata;
            state_d.start = wdata[LAUNCH_BIT] & gate_en;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign word_o  = state_q.word;
    assign start_o = state_q.start;

endmodule

// File: rtl/dma_irq_unit.sv
module dma_irq_unit
    import dma_ctl_pkg::*;
#(
    parameter int NUM_CH = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [REG_W-1:0]  wdata,
    input  logic [NUM_CH-1:0] done,
    output logic [REG_W-1:0]  irq_o
);

    logic [REG_W-1:0] irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (wr_hit) begin
            irq_d[IRQ_PLAIN_W-1:0]  = wdata[IRQ_PLAIN_W-1:0];
            irq_d[REG_W-1:IRQ_FLAG_LSB] = irq_q[REG_W-1:IRQ_FLAG_LSB]
                                        & ~wdata[REG_W-1:IRQ_FLAG_LSB];
        end
        for (int n = 0; n < NUM_CH; n++) begin
            if (done[n] && irq_q[IRQ_EN_LSB + n]) begin
                irq_d[IRQ_FLAG_LSB + n] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
    import dma_ctl_pkg::*;
#(
    parameter int NUM_CH = 7,
    parameter int ADDR_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [REG_W-1:0]        bus_wdata,
    output logic [REG_W-1:0]        bus_rdata,
    input  logic [NUM_CH-1:0]       ch_done,
    output logic [NUM_CH-1:0]       ch_start,
    output logic [REG_W*NUM_CH-1:0] ch_ctrl
);

    localparam logic [ADDR_W-1:0] GCTL_A = ADDR_W'(GCTL_OFS);
    localparam logic [ADDR_W-1:0] IRQ_A  = ADDR_W'(IRQ_OFS);

    logic [REG_W-1:0] gctl_d, gctl_q;
    logic [REG_W-1:0] irq_q;
    logic [REG_W-1:0] slot_word [NUM_CH];
    logic             irq_hit;

    assign irq_hit = bus_wr && (bus_addr == IRQ_A);

    always_comb begin
        gctl_d = gctl_q;
        if (bus_wr && (bus_addr == GCTL_A)) begin
            gctl_d = bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gctl_q <= '0;
        end else begin
            gctl_q <= gctl_d;
        end
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_slot
        localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(ctrl_ofs(n));
        logic slot_hit;
        assign slot_hit = bus_wr && (bus_addr == SLOT_A);

        dma_chan_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (slot_hit),
            .wdata   (bus_wdata),
            .gate_en (gctl_q[gate_bit(n)]),
            .done    (ch_done[n]),
            .word_o  (slot_word[n]),
            .start_o (ch_start[n])
        );

        assign ch_ctrl[n*REG_W +: REG_W] = slot_word[n];
    end

    dma_irq_unit #(.NUM_CH(NUM_CH)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (irq_hit),
        .wdata  (bus_wdata),
        .done   (ch_done),
        .irq_o  (irq_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == GCTL_A) begin
            bus_rdata = gctl_q;
        end
        if (bus_addr == IRQ_A) begin
            bus_rdata = irq_q;
        end
        for (int n = 0; n < NUM_CH; n++) begin
            if (bus_addr == ADDR_W'(ctrl_ofs(n))) begin
                bus_rdata = slot_word[n];
            end
        end
    end

endmodule

// File: rtl/dma_ctl_chk.sv
module dma_ctl_chk
    import dma_ctl_pkg::*;
#(
    parameter int NUM_CH = 7,
    parameter int ADDR_W = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_wr,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic [REG_W-1:0]        bus_wdata,
    input logic [REG_W-1:0]        gctl_q,
    input logic [REG_W-1:0]        irq_q,
    input logic [NUM_CH-1:0]       ch_done,
    input logic [NUM_CH-1:0]       ch_start,
    input logic [REG_W*NUM_CH-1:0] ch_ctrl
);

    logic gctl_wr, irq_wr;
    assign gctl_wr = bus_wr && (bus_addr == ADDR_W'(GCTL_OFS));
    assign irq_wr  = bus_wr && (bus_addr == ADDR_W'(IRQ_OFS));

    assert_gctl_plain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gctl_wr |=> gctl_q == $past(bus_wdata));

    assert_irq_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_wr |=> irq_q[IRQ_PLAIN_W-1:0] == $past(bus_wdata[IRQ_PLAIN_W-1:0]));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic wr_n;
        assign wr_n = bus_wr && (bus_addr == ADDR_W'(ctrl_ofs(n)));

        assert_start_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ch_start[n] |-> $past(wr_n && bus_wdata[LAUNCH_BIT] && gctl_q[gate_bit(n)]));

        assert_no_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_n && !(bus_wdata[LAUNCH_BIT] && gctl_q[gate_bit(n)])) |=> !ch_start[n]);

        assert_done_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_done[n] && !wr_n) |=> !ch_ctrl[n*REG_W + LAUNCH_BIT]);

        assert_flag_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!irq_q[IRQ_FLAG_LSB+n] && !(ch_done[n] && irq_q[IRQ_EN_LSB+n]))
            |=> !irq_q[IRQ_FLAG_LSB+n]);

        assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_done[n] && irq_q[IRQ_EN_LSB+n]) |=> irq_q[IRQ_FLAG_LSB+n]);
    end

endmodule

bind dma_ctl_regs dma_ctl_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .gctl_q    (gctl_q),
    .irq_q     (irq_q),
    .ch_done   (ch_done),
    .ch_start  (ch_start),
    .ch_ctrl   (ch_ctrl)
);

// File: tb/dma_ctl_regs_tb.sv
module dma_ctl_regs_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 7;
    localparam int AW  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCH-1:0]    ch_done = '0;
    logic [NCH-1:0]    ch_start;
    logic [32*NCH-1:0] ch_ctrl;

    int n_checks = 0;
    int n_fails  = 0;
    logic [NCH-1:0] seen_start;
    logic [31:0]    all_gates;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_ctl_regs #(.NUM_CH(NCH), .ADDR_W(AW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ch_done   (ch_done),
        .ch_start  (ch_start),
        .ch_ctrl   (ch_ctrl)
    );

    function automatic logic [AW-1:0] cofs(input int n);
        return AW'(12'h088 + 12'h010 * n);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // One bus cycle: optional write plus done pulses; captures start after the edge.
    task automatic op(input logic wr, input logic [AW-1:0] a, input logic [31:0] d,
                      input logic [NCH-1:0] dn);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; ch_done = dn;
        @(negedge clk);
        seen_start = ch_start;
        bus_wr = 1'b0; ch_done = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(AW'(12'h0F0), v); check("R1 gctl", v, 0);
        rd(AW'(12'h0F4), v); check("R1 irq", v, 0);
        for (int n = 0; n < NCH; n++) begin
            rd(cofs(n), v); check("R1 ctrl", v, 0);
        end
        check("R1 start", 32'(ch_start), 0);
    endtask

    task automatic t_gctl();
        logic [31:0] v;
        op(1, AW'(12'h0F0), 32'hA5A5_5A5A, '0);
        rd(AW'(12'h0F0), v); check("R5 gctl readback", v, 32'hA5A5_5A5A);
        op(1, AW'(12'h0F0), 32'h0, '0);
        rd(AW'(12'h0F0), v); check("R5 gctl zero", v, 0);
    endtask

    task automatic t_store_no_gate();
        logic [31:0] v;
        for (int n = 0; n < NCH; n++) begin
            op(1, cofs(n), 32'h0100_0000 | 32'(n * 32'h111), '0);
            check("R4 no start without gate", 32'(seen_start), 0);
            rd(cofs(n), v); check("R2 ctrl readback", v, 32'h0100_0000 | 32'(n * 32'h111));
            check("R2 ctrl port", ch_ctrl[n*32 +: 32], 32'h0100_0000 | 32'(n * 32'h111));
        end
    endtask

    task automatic t_launch();
        logic [31:0] v;
        all_gates = '0;
        for (int n = 0; n < NCH; n++) all_gates[4*n+3] = 1'b1;
        op(1, AW'(12'h0F0), all_gates, '0);
        for (int n = 0; n < NCH; n++) begin
            op(1, cofs(n), 32'h0100_0040 | 32'(n), '0);
            check("R3 start pulse", 32'(seen_start), 32'(1) << n);
            @(negedge clk);
            check("R3 pulse one cycle", 32'(ch_start), 0);
            op(1, cofs(n), 32'h0000_0040, '0);
            check("R4 no start bit24 clear", 32'(seen_start), 0);
        end
        op(1, AW'(12'h0F0), all_gates & ~32'h0000_0080, '0);
        op(1, cofs(1), 32'h0100_0000, '0);
        check("R4 gate cleared", 32'(seen_start), 0);
        op(1, cofs(2), 32'h0100_0000, '0);
        check("R3 other gate still on", 32'(seen_start), 32'h4);
        rd(cofs(1), v); check("R4 stored anyway", v, 32'h0100_0000);
    endtask

    task automatic t_done();
        logic [31:0] v;
        op(1, cofs(3), 32'hFFFF_FFFF, '0);
        op(0, '0, '0, 7'b000_1000);
        rd(cofs(3), v); check("R8 done clears bit24", v, 32'hFEFF_FFFF);
        rd(cofs(2), v); check("R8 other channel kept", v, 32'h0100_0000);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        op(1, AW'(12'h0F4), 32'h007F_1234, '0);
        rd(AW'(12'h0F4), v); check("R6 low bits", v, 32'h007F_1234);
        op(0, '0, '0, 7'h7F);
        rd(AW'(12'h0F4), v); check("R9 flags set", v, 32'h7F7F_1234);
        op(1, AW'(12'h0F4), 32'h057F_ABCD, '0);
        rd(AW'(12'h0F4), v); check("R7 w1c", v, 32'h7A7F_ABCD);
        op(1, AW'(12'h0F4), 32'h0000_0001, '0);
        rd(AW'(12'h0F4), v); check("R7 zero keeps", v, 32'h7A00_0001);
        op(0, '0, '0, 7'h7F);
        rd(AW'(12'h0F4), v); check("R7 flags kept", v, 32'h7A00_0001);
        op(1, AW'(12'h0F4), 32'hFF00_0000, '0);
        rd(AW'(12'h0F4), v); check("R7 all clear", v, 32'h0);
        op(0, '0, '0, 7'h7F);
        rd(AW'(12'h0F4), v); check("R9 disabled no flag", v, 32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        op(1, AW'(12'h0F4), 32'h0001_0000, '0);
        op(0, '0, '0, 7'h01);
        op(1, AW'(12'h0F4), 32'h0101_0000, 7'h01);
        rd(AW'(12'h0F4), v); check("R10 set beats clear", v, 32'h0101_0000);
        op(1, cofs(5), 32'h0100_0005, 7'h20);
        rd(cofs(5), v); check("R10 write beats done", v, 32'h0100_0005);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        op(1, AW'(12'h0FC), 32'hDEAD_BEEF, '0);
        op(1, AW'(12'h08C), 32'hDEAD_BEEF, '0);
        op(1, AW'(12'h0F8), 32'hDEAD_BEEF, '0);
        rd(AW'(12'h0FC), v); check("R11 read zero", v, 0);
        rd(AW'(12'h08C), v); check("R11 read zero gap", v, 0);
        rd(AW'(12'h0F0), v); check("R11 gctl intact", v, all_gates & ~32'h0000_0080);
        rd(AW'(12'h0F4), v); check("R11 irq intact", v, 32'h0101_0000);
        rd(cofs(0), v); check("R11 ctrl intact", v, 32'h0000_0040);
        rd(cofs(6), v); check("R11 ctrl6 intact", v, 32'h0000_0040);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gctl();
        t_store_no_gate();
        t_launch();
        t_done();
        t_irq();
        t_collide();
        t_unmapped();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule